// File: doc/BRIEF.md
# Memory-Resident Workspace Context Switcher

This block sequences context switches for a processor whose sixteen general registers are kept in main memory rather than in flip-flops. Only three hard registers are held inside: a workspace pointer, a program counter and a status word. General register n is the memory word at the workspace pointer plus 2n. Loading a new pointer therefore relocates the whole register file in one step.

A call request takes a vector address and reads two consecutive words from it. The first word is the new workspace pointer and the second is the new entry point. The block then stores the old pointer, program counter and status into registers 13, 14 and 15 of the new workspace. Only after the last of these writes does it commit the new pointer and program counter; status is carried over unchanged. A return request reloads all three hard registers from registers 13, 14 and 15 of the current workspace. Register 13 is read last, so the two earlier reads still use the old base.

Memory is byte addressed with 16-bit words and has a synchronous port: a read issued in one cycle returns its data in the next cycle. Every address the block issues is even. Loaded pointers and program counters have bit 0 cleared.

Top module: `wsp_ctx_seq`

## Requirements
- R1: While reset is asserted and after it is released, the pointer is 0x0080, the program counter is 0x0400 and the status is 0xC00F. Busy, done and the memory request are low.
- R2: A call request with vector address V issues two reads in consecutive cycles: first at V with bit 0 cleared (call it A), then at A+2.
- R3: After the two vector reads, the call issues three writes in consecutive cycles. Let NW be the first vector word with bit 0 cleared. The writes are the old pointer to NW+26, then the old program counter to NW+28, then the old status to NW+30.
- R4: When a call completes, the pointer equals NW and the program counter equals the second vector word with bit 0 cleared. Status is unchanged. None of the three hard registers changes before the done cycle.
- R5: A return request issues three reads in consecutive cycles, at WP+28, then WP+30, then WP+26, where WP is the current pointer.
- R6: When a return completes, the program counter is the word read from WP+28 with bit 0 cleared. The status is the full word read from WP+30. The pointer is the word read from WP+26 with bit 0 cleared.
- R7: Busy rises in the cycle after a request is accepted and stays high for the whole sequence. A call keeps busy high for 6 cycles and a return for 5. Done is high only in the last busy cycle, for exactly one cycle.
- R8: Requests that arrive while busy is high are ignored: they cause no memory access and no register change. When a call and a return are requested in the same cycle, the call is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| call_req | input | 1 | Start a branch-and-load-workspace sequence |
| call_vec | input | 16 | Byte address of the two-word vector |
| ret_req | input | 1 | Start a return sequence |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle pulse in the final cycle of a sequence |
| wp_q | output | 16 | Workspace pointer |
| pc_q | output | 16 | Program counter |
| st_q | output | 16 | Status word |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 16 | Byte address of the access |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid the cycle after a read request |

## Verification
The case hardest to reach from the ports is one where the return's program counter and status reads depend on the old base. The stimulus makes them differ visibly from the new base. A nested pair of calls with hand-edited saved words sets this up: the saved status is overwritten with a distinctive value, and the saved pointer is given an odd value. Requests are also injected in the middle of a busy sequence, and a call and a return are raised together. The scoreboard then confirms that no extra access ever appears and that the call alone runs.

// File: rtl/wsp_ctx_seq.sv
module wsp_ctx_seq #(
  parameter int DW = 16,
  parameter logic [DW-1:0] RST_WP = 16'h0080,
  parameter logic [DW-1:0] RST_PC = 16'h0400,
  parameter logic [DW-1:0] RST_ST = 16'hC00F
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          call_req,
  input  logic [DW-1:0] call_vec,
  input  logic          ret_req,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] wp_q,
  output logic [DW-1:0] pc_q,
  output logic [DW-1:0] st_q,
  output logic          mem_req,
  output logic          mem_we,
  output logic [DW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata
);
  localparam int WBYTES = DW / 8;
  localparam logic [DW-1:0] EVEN  = ~DW'(1);
  localparam logic [DW-1:0] STEP  = DW'(WBYTES);
  localparam logic [DW-1:0] OFF13 = DW'(13 * WBYTES);
  localparam logic [DW-1:0] OFF14 = DW'(14 * WBYTES);
  localparam logic [DW-1:0] OFF15 = DW'(15 * WBYTES);

  typedef enum logic [3:0] {
    S_IDLE, S_V0, S_V1, S_W13, S_W14, S_W15,
    S_R14, S_R15, S_R13, S_RCAP, S_DONE
  } state_t;

  state_t        state;
  logic [DW-1:0] vec_q, t_a, t_b;

  assign busy = (state != S_IDLE);
  assign done = (state == S_DONE);
  assign mem_we = (state == S_W13) || (state == S_W14) || (state == S_W15);
  assign mem_req = mem_we || (state == S_V0) || (state == S_V1) ||
                   (state == S_R14) || (state == S_R15) || (state == S_R13);

  always_comb begin
    mem_addr  = '0;
    mem_wdata = '0;
    case (state)
      S_V0:  mem_addr = vec_q;
      S_V1:  mem_addr = vec_q + STEP;
      S_W13: begin mem_addr = t_a + OFF13; mem_wdata = wp_q; end
      S_W14: begin mem_addr = t_a + OFF14; mem_wdata = pc_q; end
      S_W15: begin mem_addr = t_a + OFF15; mem_wdata = st_q; end
      S_R14: mem_addr = wp_q + OFF14;
      S_R15: mem_addr = wp_q + OFF15;
      S_R13: mem_addr = wp_q + OFF13;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      wp_q  <= RST_WP;
      pc_q  <= RST_PC;
      st_q  <= RST_ST;
      vec_q <= '0;
      t_a   <= '0;
      t_b   <= '0;
    end else begin
      case (state)
        S_IDLE:
          if (call_req) begin
            vec_q <= call_vec & EVEN;
            state <= S_V0;
          end else if (ret_req) begin
            state <= S_R14;
          end
        S_V0:  state <= S_V1;
        S_V1:  begin t_a <= mem_rdata & EVEN; state <= S_W13; end
        S_W13: begin t_b <= mem_rdata & EVEN; state <= S_W14; end
        S_W14: state <= S_W15;
        S_W15: begin
          wp_q  <= t_a;
          pc_q  <= t_b;
          state <= S_DONE;
        end
        S_R14: state <= S_R15;
        S_R15: begin t_a <= mem_rdata & EVEN; state <= S_R13; end
        S_R13: begin t_b <= mem_rdata; state <= S_RCAP; end
        S_RCAP: begin
          wp_q  <= mem_rdata & EVEN;
          pc_q  <= t_a;
          st_q  <= t_b;
          state <= S_DONE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wsp_ctx_seq_chk.sv
module wsp_ctx_seq_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          mem_req,
  input logic [DW-1:0] mem_addr,
  input logic [DW-1:0] wp_q,
  input logic [DW-1:0] pc_q,
  input logic [DW-1:0] st_q
);
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_in_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);
  p_req_needs_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy);
  p_even_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !mem_addr[0]);
  p_wp_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(wp_q));
  p_pc_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(pc_q));
  p_st_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(st_q));
  p_even_wp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !wp_q[0] && !pc_q[0]);
endmodule

bind wsp_ctx_seq wsp_ctx_seq_chk #(.DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
  .mem_req(mem_req), .mem_addr(mem_addr),
  .wp_q(wp_q), .pc_q(pc_q), .st_q(st_q)
);

// File: tb/wsp_ctx_seq_tb_top.sv
module wsp_ctx_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic call_req = 1'b0, ret_req = 1'b0;
  logic [15:0] call_vec = '0;
  logic busy, done, mem_req, mem_we;
  logic [15:0] wp_q, pc_q, st_q, mem_addr, mem_wdata;
  logic [15:0] mem_rdata = '0;

  always #2.5 clk = ~clk;

  wsp_ctx_seq dut_i (
    .clk(clk), .rst_n(rst_n), .call_req(call_req), .call_vec(call_vec),
    .ret_req(ret_req), .busy(busy), .done(done), .wp_q(wp_q), .pc_q(pc_q),
    .st_q(st_q), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  logic [15:0] mem [int];
  function automatic logic [15:0] rd(logic [15:0] a);
    return mem.exists(int'(a)) ? mem[int'(a)] : 16'h0000;
  endfunction

  always @(posedge clk) begin
    if (mem_req && !mem_we) mem_rdata <= rd(mem_addr);
    if (mem_req && mem_we) mem[int'(mem_addr)] = mem_wdata;
  end

  typedef struct packed { logic we; logic [15:0] addr; logic [15:0] data; } item_t;
  item_t exp_q[$];
  string tag_q[$];
  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic chk(bit ok, string tag, logic [15:0] act, logic [15:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  always @(negedge clk) if (rst_n && mem_req) begin
    if (exp_q.size() == 0) chk(0, "R8 unexpected access", mem_addr, 16'hxxxx);
    else begin
      item_t e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(mem_we == e.we, {t, " write-enable"}, {15'd0, mem_we}, {15'd0, e.we});
      chk(mem_addr == e.addr, {t, " address"}, mem_addr, e.addr);
      if (e.we) chk(mem_wdata == e.data, {t, " write data"}, mem_wdata, e.data);
    end
  end

  logic [15:0] m_wp = 16'h0080, m_pc = 16'h0400, m_st = 16'hC00F;

  task automatic push(logic we, logic [15:0] a, logic [15:0] d, string t);
    exp_q.push_back('{we, a, d});
    tag_q.push_back(t);
  endtask

  task automatic wait_done(int exp_cycles, bit inject, string tag);
    int n = 0;
    forever begin
      @(negedge clk);
      if (inject && n == 1) begin call_req = 1; ret_req = 1; call_vec = 16'h0500; end
      else begin call_req = 0; ret_req = 0; end
      if (busy) n++;
      if (done) break;
      chk(wp_q == m_wp && pc_q == m_pc, "R4 registers held during sequence", wp_q, m_wp);
      if (n > 20) break;
    end
    call_req = 0; ret_req = 0;
    chk(n == exp_cycles, {tag, " busy length"}, 16'(n), 16'(exp_cycles));
    @(negedge clk);
    chk(!done && !busy, "R7 done single pulse", {15'd0, done}, 16'h0);
  endtask

  task automatic do_call(logic [15:0] v, bit with_ret, bit inject);
    logic [15:0] a, nw, np;
    a = v & 16'hFFFE;
    nw = rd(a) & 16'hFFFE;
    np = rd(a + 16'd2) & 16'hFFFE;
    push(0, a, 0, "R2 vector word 0");
    push(0, a + 16'd2, 0, "R2 vector word 1");
    push(1, nw + 16'd26, m_wp, "R3 save pointer");
    push(1, nw + 16'd28, m_pc, "R3 save pc");
    push(1, nw + 16'd30, m_st, "R3 save status");
    @(negedge clk);
    call_vec = v; call_req = 1; ret_req = with_ret;
    wait_done(6, inject, "R7 call");
    m_wp = nw; m_pc = np;
    chk(wp_q == m_wp, "R4 new pointer", wp_q, m_wp);
    chk(pc_q == m_pc, "R4 new pc", pc_q, m_pc);
    chk(st_q == m_st, "R4 status kept", st_q, m_st);
    chk(exp_q.size() == 0, "R8 no missing access", 16'(exp_q.size()), 16'h0);
  endtask

  task automatic do_ret(bit inject);
    logic [15:0] nw, np, ns;
    nw = rd(m_wp + 16'd26) & 16'hFFFE;
    np = rd(m_wp + 16'd28) & 16'hFFFE;
    ns = rd(m_wp + 16'd30);
    push(0, m_wp + 16'd28, 0, "R5 read r14");
    push(0, m_wp + 16'd30, 0, "R5 read r15");
    push(0, m_wp + 16'd26, 0, "R5 read r13");
    @(negedge clk);
    ret_req = 1;
    wait_done(5, inject, "R7 return");
    m_wp = nw; m_pc = np; m_st = ns;
    chk(wp_q == m_wp, "R6 restored pointer", wp_q, m_wp);
    chk(pc_q == m_pc, "R6 restored pc", pc_q, m_pc);
    chk(st_q == m_st, "R6 restored status", st_q, m_st);
    chk(exp_q.size() == 0, "R8 no missing access", 16'(exp_q.size()), 16'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    mem[16'h0100] = 16'h2001; mem[16'h0102] = 16'h4567;
    mem[16'h0300] = 16'h3000; mem[16'h0302] = 16'h5000;
    mem[16'h0500] = 16'h6000; mem[16'h0502] = 16'h7002;
    repeat (3) @(negedge clk);
    chk(wp_q == 16'h0080 && pc_q == 16'h0400 && st_q == 16'hC00F, "R1 reset regs in reset", wp_q, 16'h0080);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !done && !mem_req, "R1 idle after reset", {13'd0, busy, done, mem_req}, 16'h0);
    chk(st_q == 16'hC00F && pc_q == 16'h0400, "R1 reset status", st_q, 16'hC00F);

    do_call(16'h0101, 0, 0);
    do_call(16'h0300, 0, 0);
    mem[16'h3000 + 26] = 16'h2001;
    mem[16'h3000 + 30] = 16'hA5A5;
    do_ret(0);
    chk(m_wp == 16'h2000, "R6 odd saved pointer cleared", wp_q, 16'h2000);
    do_ret(1);
    repeat (4) @(negedge clk);
    chk(!busy, "R8 injected requests ignored", {15'd0, busy}, 16'h0);
    do_call(16'h0500, 1, 1);
    repeat (4) @(negedge clk);
    chk(!busy && exp_q.size() == 0, "R8 call wins and mid-sequence requests ignored", {15'd0, busy}, 16'h0);
    do_ret(0);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule